// File: doc/BRIEF.md
# Serial Frame Integrity Checker

This block watches the bit stream that a serial shift register captures. It decides whether each completed frame may be committed. Framing is delimited by a select line that is low while a frame is being clocked in. Each accepted bit is announced by a one-cycle valid strobe in the system clock domain. When the select line returns high, the block looks at how many bits arrived. A 16-bit frame is trusted as it stands. A 24-bit frame carries a 16-bit payload followed by an 8-bit checksum, and the block recomputes that checksum before it lets the payload through.

A frame that passes raises a one-cycle write permit and presents its 16-bit payload. Any other outcome withholds the permit and sets a sticky integrity-error flag. The outcomes are a bad checksum or an unsupported length. The flag can drive a fault line and stays set until the host signals that it has read the status word. Address decoding and register storage belong to the neighbouring logic.

Top module: `frame_crc_guard`

## Requirements
- R1: After reset, writePermit is 0, pecError is 0 and dataWord is 0.
- R2: A frame of exactly 16 bits, taken MSB first, passes with no checksum test. writePermit pulses and dataWord equals the 16 bits.
- R3: In a 24-bit frame, the first 16 bits are the payload, MSB first, and the last 8 bits are the checksum. The checksum must equal CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00 and no final XOR, taken bit-serially over the payload MSB first. When it matches, writePermit pulses and dataWord equals the payload.
- R4: A 24-bit frame whose checksum does not match gives no writePermit and sets pecError. dataWord keeps its previous value.
- R5: pecError stays set across later frames, passing ones included. It is cleared only by a statusRead pulse.
- R6: writePermit is high for exactly one cycle. It rises in the cycle after the first clock edge at which syncIn is sampled high at the end of a frame.
- R7: A frame whose bit count is neither 16 nor 24 gives no writePermit and sets pecError. Short, in-between and overlong lengths all count.
- R8: bitValid strobes while syncIn is high do not enter the next frame.
- R9: If statusRead coincides with the end of a failing frame, pecError ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Frame select, low during a frame; its rise ends the frame |
| bitValid | input | 1 | One-cycle strobe: bitIn holds a captured bit |
| bitIn | input | 1 | Captured serial bit |
| statusRead | input | 1 | Pulse: host has read the status word |
| writePermit | output | 1 | One-cycle permit to commit dataWord |
| dataWord | output | 16 | Payload of the last accepted frame |
| pecError | output | 1 | Sticky integrity-error flag |

## Verification
Several 24-bit frames with distinct payloads are each sent with their correct checksum, and once with one flipped checksum bit. This tells real checksum evaluation apart from a length-only test or a constant comparison. Plain 16-bit frames show that the checksum path is bypassed. Frames of 8 and 25 bits separate a true length decode from a "16 or more" test. Read pulses placed before, during and after failures tell a sticky flag apart from one that is level-driven, and show which of set and clear wins.

// File: rtl/frame_crc_guard_pkg.sv
package frame_crc_guard_pkg;
  typedef struct packed {
    logic shiftEn;
    logic frameEnd;
  } guardStrobes_t;
endpackage

// File: rtl/frame_crc_guard_ctrl.sv
module frame_crc_guard_ctrl
  import frame_crc_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncIn,
  input  logic          bitValid,
  output guardStrobes_t strobes
);
  logic syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 1'b1;
    else       syncQ <= syncIn;
  end

  always_comb begin
    strobes.shiftEn  = bitValid && !syncIn;
    strobes.frameEnd = syncIn && !syncQ;
  end
endmodule

// File: rtl/frame_crc_guard_dp.sv
module frame_crc_guard_dp
  import frame_crc_guard_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              statusRead,
  input  guardStrobes_t     strobes,
  output logic              writePermit,
  output logic [DATA_W-1:0] dataWord,
  output logic              pecError
);
  localparam int FRAME_W = DATA_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_PROT  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] shiftReg;
  logic [CRC_W-1:0]   crcReg, crcNext;
  logic               lenShort, lenProt, crcOk, framePass;

  always_comb begin
    crcNext = {crcReg[CRC_W-2:0], 1'b0} ^ ((crcReg[CRC_W-1] ^ bitIn) ? POLY : '0);
    lenShort  = (bitCnt == CNT_SHORT);
    lenProt   = (bitCnt == CNT_PROT);
    crcOk     = (crcReg == shiftReg[CRC_W-1:0]);
    framePass = lenShort || (lenProt && crcOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt      <= '0;
      shiftReg    <= '0;
      crcReg      <= '0;
      writePermit <= 1'b0;
      dataWord    <= '0;
      pecError    <= 1'b0;
    end else if (strobes.frameEnd) begin
      bitCnt      <= '0;
      crcReg      <= '0;
      writePermit <= framePass;
      if (framePass)
        dataWord <= lenShort ? shiftReg[DATA_W-1:0] : shiftReg[FRAME_W-1:CRC_W];
      if (!framePass)      pecError <= 1'b1;
      else if (statusRead) pecError <= 1'b0;
    end else begin
      writePermit <= 1'b0;
      if (statusRead) pecError <= 1'b0;
      if (strobes.shiftEn) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], bitIn};
        if (bitCnt != CNT_SAT)  bitCnt <= bitCnt + 1'b1;
        if (bitCnt < CNT_SHORT) crcReg <= crcNext;
      end
    end
  end
endmodule

// File: rtl/frame_crc_guard.sv
module frame_crc_guard
  import frame_crc_guard_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              statusRead,
  output logic              writePermit,
  output logic [DATA_W-1:0] dataWord,
  output logic              pecError
);
  guardStrobes_t strobes;

  frame_crc_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .bitValid(bitValid), .strobes(strobes)
  );

  frame_crc_guard_dp #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .statusRead(statusRead), .strobes(strobes),
    .writePermit(writePermit), .dataWord(dataWord), .pecError(pecError)
  );
endmodule

// File: rtl/frame_crc_guard_chk.sv
module frame_crc_guard_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              syncIn,
  input logic              statusRead,
  input logic              writePermit,
  input logic [DATA_W-1:0] dataWord,
  input logic              pecError
);
  p_permit_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |=> !writePermit);
  p_permit_after_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |-> ($past(syncIn) && !$past(syncIn, 2)));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pecError && !statusRead) |=> pecError);
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !syncIn) |=> !pecError);
  p_no_permit_on_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pecError) |-> !writePermit);
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !writePermit |-> $stable(dataWord));
endmodule

bind frame_crc_guard frame_crc_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .statusRead(statusRead),
  .writePermit(writePermit), .dataWord(dataWord), .pecError(pecError)
);

// File: tb/tb_frame_crc_guard.sv
module tb_frame_crc_guard;
  logic clk = 0, rstN = 0, syncIn = 1, bitValid = 0, bitIn = 0, statusRead = 0;
  logic writePermit, pecError;
  logic [15:0] dataWord;
  int checks = 0, errors = 0;
  logic [15:0] lastData = 16'h0;

  always #10 clk = ~clk;

  frame_crc_guard dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .bitValid(bitValid), .bitIn(bitIn),
    .statusRead(statusRead), .writePermit(writePermit), .dataWord(dataWord), .pecError(pecError)
  );

  function automatic logic [7:0] crc8(input logic [15:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bitIn = v[i]; bitValid = 1;
      @(negedge clk); bitValid = 0;
    end
  endtask

  // sends n bits, ends frame; checks permit timing, flag and data
  task automatic frame(input string req, input logic [31:0] v, input int n,
                       input logic expPass, input logic rdAtEnd);
    @(negedge clk); syncIn = 0;
    shiftBits(v, n);
    @(negedge clk); syncIn = 1; statusRead = rdAtEnd;
    @(negedge clk); statusRead = 0;
    chk({req, " permit"}, writePermit, expPass);
    if (expPass) lastData = (n == 16) ? v[15:0] : v[23:8];
    chk({req, " data"}, dataWord, lastData);
    if (!expPass) chk({req, " flag"}, pecError, 1);
    @(negedge clk);
    chk({req, " pulse end R6"}, writePermit, 0);
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1;
    @(negedge clk); statusRead = 0;
  endtask

  task automatic t_reset();
    chk("R1 permit", writePermit, 0);
    chk("R1 flag", pecError, 0);
    chk("R1 data", dataWord, 0);
  endtask

  task automatic t_short();
    frame("R2 a", 32'hA5C3, 16, 1, 0);
    frame("R2 b", 32'h0001, 16, 1, 0);
    chk("R2 no err", pecError, 0);
  endtask

  task automatic t_protected();
    frame("R3 a", {8'h0, 16'h1234, crc8(16'h1234)}, 24, 1, 0);
    frame("R3 b", {8'h0, 16'hFFFF, crc8(16'hFFFF)}, 24, 1, 0);
    frame("R3 c", {8'h0, 16'h8001, crc8(16'h8001)}, 24, 1, 0);
    chk("R3 no err", pecError, 0);
  endtask

  task automatic t_badcrc();
    frame("R4 bad", {8'h0, 16'h5A5A, crc8(16'h5A5A) ^ 8'h10}, 24, 0, 0);
  endtask

  task automatic t_sticky();
    frame("R5 good after err", 32'h7777, 16, 1, 0);
    chk("R5 still set", pecError, 1);
    readStatus();
    @(negedge clk);
    chk("R5 cleared", pecError, 0);
  endtask

  task automatic t_lengths();
    frame("R7 len8", 32'h00C3, 8, 0, 0);
    readStatus();
    frame("R7 len25", {7'h0, 1'b1, 16'h1234, crc8(16'h1234)}, 25, 0, 0);
    readStatus();
    @(negedge clk);
    chk("R7 cleared", pecError, 0);
  endtask

  task automatic t_ignore();
    shiftBits(32'hFF, 8); // syncIn high
    frame("R8 clean", 32'h3C3C, 16, 1, 0);
    chk("R8 no err", pecError, 0);
  endtask

  task automatic t_collide();
    frame("R9 read at fail", {8'h0, 16'h4242, ~crc8(16'h4242)}, 24, 0, 1);
    chk("R9 flag kept", pecError, 1);
    readStatus();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_short();
    t_protected();
    t_badcrc();
    t_sticky();
    t_lengths();
    t_ignore();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule